// File: doc/BRIEF.md
# LCD Frame and Phase Sequencer

This block produces the timing skeleton of a multiplexed segment display driver. It is clocked by the system clock and advances only on cycles where a prescaled clock enable is high. Each phase lasts a fixed number of prescaled ticks. A frame has one phase per active common line, and the number of commons comes from a duty setting. Frames come in even/odd pairs, and a programmable number of idle (dead) phases can follow each pair.

At the start of every active phase a pulse-on strobe is raised for a programmable number of prescaled ticks. A one-cycle start-of-frame pulse marks every new frame. That pulse sets a sticky flag, which software clears by writing one, and the flag drives an interrupt line through an enable bit. The enabled status rises one clock after the enable bit is seen high. After the enable bit drops, the status stays high until the frame on the glass has finished.

Frame-control settings (duty, dead time, pulse length, high-drive) are first written into a pending copy. They take effect only while the sequencer is idle or at the end of a frame pair. A synchronization flag shows when the latest write has taken effect.

Top module: `lcdfp_sequencer`

## Requirements
- R1: While reset is held, com_idx, odd_frame, pulse_on, sof_pulse, sof_flag, sof_irq, enabled and cfg_synced are all 0.
- R2: A frame has cfg_duty+1 phases, and com_idx counts from 0 up to cfg_duty before wrapping. Each phase lasts PHASE_TICKS cycles in which ps_tick is high, and no phase advances in a cycle where ps_tick is low.
- R3: Frames alternate even/odd, with odd_frame 0 in the first frame of a pair and 1 in the second. sof_pulse is high for exactly the first cycle of every frame, with com_idx at 0.
- R4: After the odd frame of a pair, cfg_dead phases of PHASE_TICKS ticks each pass before the next pair starts. No idle phase is placed between the two frames of a pair. During idle phases com_idx and odd_frame are 0 and pulse_on is low.
- R5: In each active phase, pulse_on is high for the first cfg_pulse prescaled ticks. A value of 0 gives no pulse at all.
- R6: cfg_err is high whenever the pending setting has high-drive set and a pulse length other than 1.
- R7: sof_flag is set by sof_pulse and cleared by a one on sof_clr. Setting wins when both happen in the same cycle. sof_irq equals sof_flag AND sof_ie.
- R8: enabled rises one clock after enable is sampled high while idle. After enable falls, enabled stays high until the last phase of the current frame ends, then falls and no further sof_pulse occurs.
- R9: Settings written with cfg_wr take effect only while idle or at the end of an odd frame, so a running pair keeps its old settings. cfg_synced is 0 in the cycle after a write and becomes 1 once the write has taken effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps_tick | input | 1 | Prescaled clock enable |
| enable | input | 1 | Display enable bit |
| cfg_wr | input | 1 | Write strobe for the pending frame-control setting |
| cfg_duty | input | 3 | Active commons minus one |
| cfg_dead | input | 3 | Idle phases after each frame pair |
| cfg_pulse | input | 3 | Pulse-on length in prescaled ticks |
| cfg_hdrive | input | 1 | High-drive mode request |
| sof_clr | input | 1 | Write-one-to-clear for sof_flag |
| sof_ie | input | 1 | Start-of-frame interrupt enable |
| com_idx | output | 3 | Active common index |
| odd_frame | output | 1 | 1 in the second frame of a pair |
| pulse_on | output | 1 | Pulse-on window strobe |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| sof_flag | output | 1 | Sticky start-of-frame flag |
| sof_irq | output | 1 | Start-of-frame interrupt |
| enabled | output | 1 | Controller running status |
| cfg_synced | output | 1 | Latest setting has taken effect |
| cfg_err | output | 1 | High-drive with illegal pulse length |

## Verification
The bench walks a table of settings from one common up to eight, with dead times of 0 to 7 and pulse lengths of 0 to 7. For each setting it measures the spacing of start-of-frame pulses and the number of pulse-on cycles per pair. A design that put the dead time between every frame, or that wrapped com_idx one step late, would show the wrong spacing. A design that emitted a pulse for a length of 0 would show the wrong pulse count.

Directed cases cover the following:
- Dropping enable mid-frame, where a design that stops at once would pull enabled low about twenty cycles early.
- Changing the setting mid-pair, where an early take-over would lengthen pulses inside the running pair and set cfg_synced too soon.
- A clear that lands in the same cycle as a new frame.
- A slowed prescaled tick.

// File: rtl/lcdfp_pkg.sv
package lcdfp_pkg;
    localparam int COM_W = 3;   // width of common index / duty setting
    localparam int SET_W = 3;   // width of dead-time and pulse settings

    typedef struct packed {
        logic [COM_W-1:0] duty;
        logic [SET_W-1:0] dead;
        logic [SET_W-1:0] pon;
        logic             hd;
    } lcdfp_cfg_t;

    typedef struct packed {
        logic [COM_W-1:0] duty;
        logic [SET_W-1:0] pon;
    } lcdfp_act_t;
endpackage

// File: rtl/lcdfp_cfg.sv
module lcdfp_cfg
    import lcdfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             load,
    input  lcdfp_cfg_t       wr_cfg,
    output lcdfp_act_t       act,
    output logic [SET_W-1:0] pend_dead,
    output logic             synced,
    output logic             err
);
    typedef struct packed {
        lcdfp_cfg_t pend;
        lcdfp_act_t act;
        logic       synced;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.act.duty = q.pend.duty;
            d.act.pon  = q.pend.pon;
            d.synced   = 1'b1;
        end
        if (wr) begin
            d.pend   = wr_cfg;
            d.synced = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act       = q.act;
    assign pend_dead = q.pend.dead;
    assign synced    = q.synced;
    // R6: high-drive demands a pulse of exactly one tick
    assign err       = q.pend.hd && (q.pend.pon != SET_W'(1));

    // R9
    sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !synced);
endmodule

// File: rtl/lcdfp_core.sv
module lcdfp_core
    import lcdfp_pkg::*;
#(
    parameter int PHASE_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps_tick,
    input  logic             enable,
    input  lcdfp_act_t       act,
    input  logic [SET_W-1:0] pend_dead,
    output logic             load,
    output logic [COM_W-1:0] com,
    output logic             odd,
    output logic             sof,
    output logic             run,
    output logic             pulse_on
);
    localparam int TW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(PHASE_TICKS - 1);

    typedef struct packed {
        logic             run;
        logic             dead;
        logic             odd;
        logic             sof;
        logic [COM_W-1:0] com;
        logic [SET_W-1:0] dleft;
        logic [TW-1:0]    tick;
    } st_t;

    st_t q, d;
    logic phase_end;

    always_comb begin
        d         = q;
        d.sof     = 1'b0;
        load      = 1'b0;
        phase_end = ps_tick && (q.tick == T_LAST);
        if (!q.run) begin
            // idle: settings flow through, wait for enable
            load   = 1'b1;
            d.com  = '0;
            d.odd  = 1'b0;
            d.dead = 1'b0;
            d.tick = '0;
            if (enable) begin
                d.run = 1'b1;
                d.sof = 1'b1;
            end
        end else if (ps_tick) begin
            d.tick = phase_end ? '0 : q.tick + 1'b1;
            if (phase_end) begin
                if (q.dead) begin
                    // R4: count down idle phases, then open a new pair
                    if (q.dleft == SET_W'(1)) begin
                        d.dead = 1'b0;
                        d.sof  = 1'b1;
                    end else begin
                        d.dleft = q.dleft - 1'b1;
                    end
                end else if (q.com == act.duty) begin
                    // R2: last common of the frame
                    d.com = '0;
                    if (!enable) begin
                        // R8: stop only at a frame boundary
                        d.run = 1'b0;
                        d.odd = 1'b0;
                    end else if (!q.odd) begin
                        d.odd = 1'b1;
                        d.sof = 1'b1;
                    end else begin
                        // R9: pair boundary takes in the pending setting
                        load  = 1'b1;
                        d.odd = 1'b0;
                        if (pend_dead != '0) begin
                            d.dead  = 1'b1;
                            d.dleft = pend_dead;
                        end else begin
                            d.sof = 1'b1;
                        end
                    end
                end else begin
                    d.com = q.com + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign com      = q.com;
    assign odd      = q.odd;
    assign sof      = q.sof;
    assign run      = q.run;
    // R5: window opens at tick 0 of every active phase
    assign pulse_on = q.run && !q.dead && (32'(q.tick) < 32'(act.pon));

    // R2
    com_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !q.dead) |-> (q.com <= act.duty));
    // R3
    sof_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sof |-> (q.com == '0 && q.tick == '0 && !q.dead));
    // R4
    dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.dead |-> (q.com == '0 && !q.odd && !pulse_on));
    // R8
    stop_needs_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.run) |-> !$past(enable));
endmodule

// File: rtl/lcdfp_sof.sv
module lcdfp_sof (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (clr) d.flag = 1'b0;
        if (set) d.flag = 1'b1;   // R7: set wins over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag = q.flag;
    assign irq  = q.flag && ie;

    // R7
    sof_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/lcdfp_sequencer.sv
module lcdfp_sequencer
    import lcdfp_pkg::*;
#(
    parameter int PHASE_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps_tick,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [COM_W-1:0] cfg_duty,
    input  logic [SET_W-1:0] cfg_dead,
    input  logic [SET_W-1:0] cfg_pulse,
    input  logic             cfg_hdrive,
    input  logic             sof_clr,
    input  logic             sof_ie,
    output logic [COM_W-1:0] com_idx,
    output logic             odd_frame,
    output logic             pulse_on,
    output logic             sof_pulse,
    output logic             sof_flag,
    output logic             sof_irq,
    output logic             enabled,
    output logic             cfg_synced,
    output logic             cfg_err
);
    lcdfp_cfg_t       wr_cfg;
    lcdfp_act_t       act;
    logic [SET_W-1:0] pend_dead;
    logic             load;

    assign wr_cfg = '{duty: cfg_duty, dead: cfg_dead, pon: cfg_pulse, hd: cfg_hdrive};

    lcdfp_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .load      (load),
        .wr_cfg    (wr_cfg),
        .act       (act),
        .pend_dead (pend_dead),
        .synced    (cfg_synced),
        .err       (cfg_err)
    );

    lcdfp_core #(.PHASE_TICKS(PHASE_TICKS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps_tick   (ps_tick),
        .enable    (enable),
        .act       (act),
        .pend_dead (pend_dead),
        .load      (load),
        .com       (com_idx),
        .odd       (odd_frame),
        .sof       (sof_pulse),
        .run       (enabled),
        .pulse_on  (pulse_on)
    );

    lcdfp_sof u_sof (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sof_pulse),
        .clr   (sof_clr),
        .ie    (sof_ie),
        .flag  (sof_flag),
        .irq   (sof_irq)
    );
endmodule

// File: tb/lcdfp_sequencer_bench.sv
module lcdfp_sequencer_bench;
    localparam int PH = 8;
    localparam int NV = 7;
    // fields: duty[10:8] dead[7:5] pulse[4:2] hdrive[1] expected_err[0]
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 3'd0, 3'd0, 1'b0, 1'b0},
        {3'd3, 3'd2, 3'd3, 1'b0, 1'b0},
        {3'd7, 3'd7, 3'd7, 1'b0, 1'b0},
        {3'd1, 3'd1, 3'd1, 1'b1, 1'b0},
        {3'd2, 3'd0, 3'd2, 1'b1, 1'b1},
        {3'd5, 3'd4, 3'd0, 1'b1, 1'b1},
        {3'd7, 3'd3, 3'd5, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ps_tick = 1'b1;
    logic enable = 1'b0, cfg_wr = 1'b0, cfg_hdrive = 1'b0, sof_clr = 1'b0, sof_ie = 1'b0;
    logic [2:0] cfg_duty = '0, cfg_dead = '0, cfg_pulse = '0;
    logic [2:0] com_idx;
    logic odd_frame, pulse_on, sof_pulse, sof_flag, sof_irq, enabled, cfg_synced, cfg_err;
    int n_chk = 0, n_bad = 0, tick_div = 1, div_cnt = 0;

    always #2 clk = ~clk;

    lcdfp_sequencer u_lcdfp_sequencer (
        .clk(clk), .rst_n(rst_n), .ps_tick(ps_tick), .enable(enable),
        .cfg_wr(cfg_wr), .cfg_duty(cfg_duty), .cfg_dead(cfg_dead),
        .cfg_pulse(cfg_pulse), .cfg_hdrive(cfg_hdrive), .sof_clr(sof_clr),
        .sof_ie(sof_ie), .com_idx(com_idx), .odd_frame(odd_frame),
        .pulse_on(pulse_on), .sof_pulse(sof_pulse), .sof_flag(sof_flag),
        .sof_irq(sof_irq), .enabled(enabled), .cfg_synced(cfg_synced),
        .cfg_err(cfg_err)
    );

    initial forever begin
        @(negedge clk);
        ps_tick = (div_cnt == 0);
        div_cnt = (div_cnt + 1) % tick_div;
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic go_idle();
        enable = 1'b0;
        do @(negedge clk); while (enabled);
    endtask

    task automatic write_cfg(input logic [2:0] du, input logic [2:0] de,
                             input logic [2:0] pu, input logic hd);
        @(negedge clk);
        cfg_duty = du; cfg_dead = de; cfg_pulse = pu; cfg_hdrive = hd; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "com_idx", int'(com_idx), 0);
        chk("R1", "odd/pulse/sof", int'({odd_frame, pulse_on, sof_pulse}), 0);
        chk("R1", "flag/irq/enabled/synced", int'({sof_flag, sof_irq, enabled, cfg_synced}), 0);
        rst_n = 1'b1;

        // table of settings walked by one loop
        for (int v = 0; v < NV; v++) begin
            int ncom, t1, t2, nsof, pulses, maxcom;
            int odd_at [3];
            logic [10:0] e;
            e = VEC[v];
            ncom = int'(e[10:8]) + 1;
            go_idle();
            write_cfg(e[10:8], e[7:5], e[4:2], e[1]);
            chk("R6", "cfg_err", int'(cfg_err), int'(e[0]));
            chk("R9", "synced after write", int'(cfg_synced), 0);
            @(negedge clk);
            chk("R9", "synced while idle", int'(cfg_synced), 1);
            enable = 1'b1;
            @(negedge clk);
            chk("R8", "enabled one clock after enable", int'(enabled), 1);
            chk("R3", "first sof", int'(sof_pulse), 1);
            odd_at[0] = int'(odd_frame);
            pulses = int'(pulse_on); maxcom = int'(com_idx);
            nsof = 1; t1 = 0; t2 = 0;
            for (int c = 1; c < 1000 && nsof < 3; c++) begin
                @(negedge clk);
                if (sof_pulse) begin
                    odd_at[nsof] = int'(odd_frame);
                    if (nsof == 1) t1 = c; else t2 = c;
                    nsof++;
                end
                if (nsof < 3) begin
                    pulses += int'(pulse_on);
                    if (int'(com_idx) > maxcom) maxcom = int'(com_idx);
                end
            end
            chk("R2", "frame length", t1, ncom * PH);
            chk("R4", "odd frame plus dead time", t2 - t1, ncom * PH + int'(e[7:5]) * PH);
            chk("R3", "odd pattern", odd_at[0] * 4 + odd_at[1] * 2 + odd_at[2], 2);
            chk("R2", "highest common", maxcom, int'(e[10:8]));
            chk("R5", "pulse cycles per pair", pulses, 2 * ncom * int'(e[4:2]));
        end

        // R7: sticky flag, clear, interrupt gating, set priority
        go_idle();
        write_cfg(3'd3, 3'd0, 3'd1, 1'b0);
        @(negedge clk); sof_clr = 1'b1; sof_ie = 1'b1;
        @(negedge clk); sof_clr = 1'b0;
        chk("R7", "flag cleared", int'({sof_flag, sof_irq}), 0);
        enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7", "flag and irq set", int'({sof_flag, sof_irq}), 3);
        sof_ie = 1'b0;
        @(negedge clk);
        chk("R7", "irq masked", int'({sof_flag, sof_irq}), 2);
        sof_clr = 1'b1;
        @(negedge clk); sof_clr = 1'b0;
        chk("R7", "write-one clears", int'(sof_flag), 0);
        do @(negedge clk); while (!sof_pulse);
        sof_clr = 1'b1;
        @(negedge clk); sof_clr = 1'b0;
        chk("R7", "set beats clear", int'(sof_flag), 1);

        // R8: disable mid-frame, status holds until frame end
        go_idle();
        enable = 1'b1;
        @(negedge clk);
        for (int c = 1; c <= 32; c++) begin
            @(negedge clk);
            if (c == 10) enable = 1'b0;
            if (c == 31) chk("R8", "enabled until frame end", int'(enabled), 1);
            if (c == 32) chk("R8", "enabled low and no sof after frame", int'({enabled, sof_pulse}), 0);
        end

        // R9: mid-pair change held until pair boundary
        go_idle();
        write_cfg(3'd1, 3'd0, 3'd2, 1'b0);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        begin
            int p_old, p_new;
            p_old = 0; p_new = 0;
            for (int c = 1; c <= 39; c++) begin
                @(negedge clk);
                if (c == 3) begin cfg_pulse = 3'd5; cfg_wr = 1'b1; end
                if (c == 4) cfg_wr = 1'b0;
                if (c == 5) chk("R9", "synced low mid-pair", int'(cfg_synced), 0);
                if (c >= 16 && c <= 23) p_old += int'(pulse_on);
                if (c == 31) chk("R9", "still pending at pair end", int'(cfg_synced), 0);
                if (c == 32) chk("R9", "synced with new pair", int'({cfg_synced, sof_pulse}), 3);
                if (c >= 32) p_new += int'(pulse_on);
            end
            chk("R9", "old pulse kept in running pair", p_old, 2);
            chk("R9", "new pulse after boundary", p_new, 5);
        end

        // R2: slowed prescaled tick stretches phases
        go_idle();
        tick_div = 3;
        write_cfg(3'd0, 3'd0, 3'd1, 1'b0);
        enable = 1'b1;
        begin
            int s [3];
            int n;
            n = 0;
            for (int c = 0; c < 200 && n < 3; c++) begin
                @(negedge clk);
                if (sof_pulse) begin s[n] = c; n++; end
            end
            chk("R2", "slow tick frame", s[2] - s[1], 3 * PH);
            chk("R2", "slow tick pair boundary", s[1] - s[0] <= 3 * PH ? 1 : 0, 1);
        end
        tick_div = 1;
        enable = 1'b0;

        summary();
        $finish;
    end
endmodule